// File: doc/BRIEF.md
# Configurable PLD Output Cell

This block is one output cell of a small sum-of-products programmable logic device. It receives the product-term results for its pin from the AND array. It turns them into a pin drive value, a tri-state enable for the pin driver, and a feedback bit that goes back into the array. Two bits shared by every cell pick the device-wide mode. Two bits local to the cell pick the polarity and whether the cell is registered, combinational or an input.

The mode bits decide three things at once: how many product terms feed the OR gate, whether one term is used as an output enable, and where the feedback bit comes from. The feedback source can be the cell's own pin, the neighbouring pin or the cell's register. The position of the cell in the row is a parameter. It matters because the two centre cells and the two end cells lose some options in certain modes. The register has an asynchronous power-up clear and a synchronous preload path for testing.

Top module: `pld_out_cell`

## Requirements
- R1: The mode is decoded from the global bits. `syn`=0 with `ac0`=1 is registered mode. `syn`=1 with `ac0`=1 is complex mode. Any other pair is simple mode, and `cfg_bad` is 1 only for `syn`=0 with `ac0`=0.
- R2: In registered mode with `ac1`=0 the cell is registered. Each rising `clk` loads the register. `pin_oe` equals the inverse of the active-low `oe_n` input. `pin_out` is the inverse of the register state.
- R3: Polarity is set by `xor_pol`, where 1 means active high and 0 means active low. This holds in every mode. For a registered cell, `pin_out` after a clock edge equals the OR of all product terms when `xor_pol`=1, and its inverse when `xor_pol`=0.
- R4: A registered cell drives `fb` with its register state.
- R5: A combinational I/O cell is any cell in complex mode, or a cell in registered mode with `ac1`=1. It ORs only `pterm[NTERM-1:1]`, applies the polarity, and uses `pterm[0]` as `pin_oe`.
- R6: In registered mode a combinational I/O cell drives `fb` from its own `pin_in`.
- R7: In complex mode `fb` equals `pin_in`. The exception is the two end cells (index 0 and NCELLS-1), where `fb` is 0.
- R8: In simple mode with `ac1`=0 the cell ORs all NTERM product terms, applies the polarity, and holds `pin_oe` at 1.
- R9: In simple mode with `ac1`=1 the cell is a dedicated input and `pin_oe` is 0.
- R10: In simple mode `fb` equals `nbr_in`. The two centre cells (index NCELLS/2-1 and NCELLS/2) are the exception: they give `fb`=0, ignore `ac1`, and always drive.
- R11: While `por_n` is low the register is cleared to 0 at once. An enabled registered pin then shows 1 whatever `xor_pol` is.
- R12: With `pre_en`=1 a rising `clk` loads `pre_val` into the register in any mode, and this takes priority over the array.
- R13: When the cell is not registered and `pre_en`=0, the register keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| pterm | input | NTERM | Product-term results from the AND array |
| oe_n | input | 1 | Shared output-enable pin, active low |
| pin_in | input | 1 | Value read back from this cell's pin |
| nbr_in | input | 1 | Value of the adjacent pin |
| syn | input | 1 | Global mode bit |
| ac0 | input | 1 | Global mode bit |
| xor_pol | input | 1 | Cell polarity, 1 = active high |
| ac1 | input | 1 | Cell configuration bit |
| pre_en | input | 1 | Preload strobe |
| pre_val | input | 1 | Value forced into the register by preload |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback into the AND array |
| cfg_bad | output | 1 | Unused global mode combination |

## Verification
The bench separates the seven-term OR from the eight-term OR by setting only `pterm[0]`. A cell that counts the enable term in the sum, or drops it in simple mode, would show the wrong `pin_out`. Feedback is checked in every mode on a middle cell, a centre cell and an end cell. A wrong source choice would show the pin, the neighbour or the register where another is required. The register tests cover the polarity through the register, a preload that overrides a contrary array value, and a register that is held while the cell is combinational. They also check that an enabled registered pin reads high after power-up reset for either polarity, which a design that put the polarity after the register would fail.

// File: rtl/pld_out_cell.sv
module pld_out_cell #(
  parameter int NTERM    = 8,
  parameter int NCELLS   = 8,
  parameter int CELL_IDX = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [NTERM-1:0] pterm,
  input  logic             oe_n,
  input  logic             pin_in,
  input  logic             nbr_in,
  input  logic             syn,
  input  logic             ac0,
  input  logic             xor_pol,
  input  logic             ac1,
  input  logic             pre_en,
  input  logic             pre_val,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb,
  output logic             cfg_bad
);
  localparam bit IS_CENTRE = (CELL_IDX == NCELLS/2 - 1) || (CELL_IDX == NCELLS/2);
  localparam bit IS_OUTER  = (CELL_IDX == 0) || (CELL_IDX == NCELLS - 1);

  typedef enum logic [1:0] {M_SIMPLE, M_COMPLEX, M_REG} mode_t;

  mode_t mode;
  logic  q;
  logic  sum_all, sum_io, reg_cell, io_cell, in_cell;

  always_comb begin
    if (syn && ac0)       mode = M_COMPLEX;
    else if (!syn && ac0) mode = M_REG;
    else                  mode = M_SIMPLE;
  end

  assign cfg_bad  = !syn && !ac0;
  assign sum_all  = |pterm;
  assign sum_io   = |pterm[NTERM-1:1];
  assign reg_cell = (mode == M_REG) && !ac1;
  assign io_cell  = ((mode == M_REG) && ac1) || (mode == M_COMPLEX);
  assign in_cell  = (mode == M_SIMPLE) && ac1 && !IS_CENTRE;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        q <= 1'b0;
    else if (pre_en)   q <= pre_val;
    else if (reg_cell) q <= sum_all ^ xor_pol;
  end

  always_comb begin
    if (reg_cell) begin
      pin_out = ~q;
      pin_oe  = ~oe_n;
    end else if (io_cell) begin
      pin_out = sum_io ~^ xor_pol;
      pin_oe  = pterm[0];
    end else begin
      pin_out = sum_all ~^ xor_pol;
      pin_oe  = ~in_cell;
    end
  end

  always_comb begin
    case (mode)
      M_REG:     fb = ac1 ? pin_in : q;
      M_COMPLEX: fb = IS_OUTER ? 1'b0 : pin_in;
      default:   fb = IS_CENTRE ? 1'b0 : nbr_in;
    endcase
  end
endmodule

module pld_out_cell_chk #(
  parameter int NTERM    = 8,
  parameter int NCELLS   = 8,
  parameter int CELL_IDX = 2
) (
  input logic             clk,
  input logic             por_n,
  input logic [NTERM-1:0] pterm,
  input logic             oe_n,
  input logic             syn,
  input logic             ac0,
  input logic             xor_pol,
  input logic             ac1,
  input logic             pre_en,
  input logic             pre_val,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             fb,
  input logic             q
);
  localparam bit IS_CENTRE = (CELL_IDX == NCELLS/2 - 1) || (CELL_IDX == NCELLS/2);
  logic is_reg;
  assign is_reg = !syn && ac0 && !ac1;

  a_r3_reg_capture: assert property (@(posedge clk) disable iff (!por_n)
    (is_reg && !pre_en) |=> (!is_reg || fb == ($past(|pterm) ^ $past(xor_pol))));
  a_r12_preload: assert property (@(posedge clk) disable iff (!por_n)
    pre_en |=> (!is_reg || fb == $past(pre_val)));
  a_r2_pin_inverts_state: assert property (@(posedge clk) disable iff (!por_n)
    (is_reg && !oe_n) |-> (pin_oe && pin_out == !fb));
  a_r9_input_driver_off: assert property (@(posedge clk) disable iff (!por_n)
    (syn && !ac0 && ac1 && !IS_CENTRE) |-> !pin_oe);
  a_r13_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!is_reg && !pre_en) |=> $stable(q));
endmodule

bind pld_out_cell pld_out_cell_chk #(.NTERM(NTERM), .NCELLS(NCELLS), .CELL_IDX(CELL_IDX)) u_chk (
  .clk(clk), .por_n(por_n), .pterm(pterm), .oe_n(oe_n), .syn(syn), .ac0(ac0),
  .xor_pol(xor_pol), .ac1(ac1), .pre_en(pre_en), .pre_val(pre_val),
  .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb), .q(q)
);

// File: tb/test_pld_out_cell.sv
module test_pld_out_cell;
  logic clk = 1'b0;
  logic por_n, oe_n, pin_in, nbr_in, syn, ac0, xor_pol, ac1, pre_en, pre_val;
  logic [7:0] pterm;
  logic m_out, m_oe, m_fb, m_bad;
  logic c_out, c_oe, c_fb, c_bad;
  logic e_out, e_oe, e_fb, e_bad;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pld_out_cell #(.NTERM(8), .NCELLS(8), .CELL_IDX(2)) i_pld_out_cell (
    .clk(clk), .por_n(por_n), .pterm(pterm), .oe_n(oe_n), .pin_in(pin_in), .nbr_in(nbr_in),
    .syn(syn), .ac0(ac0), .xor_pol(xor_pol), .ac1(ac1), .pre_en(pre_en), .pre_val(pre_val),
    .pin_out(m_out), .pin_oe(m_oe), .fb(m_fb), .cfg_bad(m_bad));
  pld_out_cell #(.NTERM(8), .NCELLS(8), .CELL_IDX(3)) i_pld_out_cell_ctr (
    .clk(clk), .por_n(por_n), .pterm(pterm), .oe_n(oe_n), .pin_in(pin_in), .nbr_in(nbr_in),
    .syn(syn), .ac0(ac0), .xor_pol(xor_pol), .ac1(ac1), .pre_en(pre_en), .pre_val(pre_val),
    .pin_out(c_out), .pin_oe(c_oe), .fb(c_fb), .cfg_bad(c_bad));
  pld_out_cell #(.NTERM(8), .NCELLS(8), .CELL_IDX(0)) i_pld_out_cell_end (
    .clk(clk), .por_n(por_n), .pterm(pterm), .oe_n(oe_n), .pin_in(pin_in), .nbr_in(nbr_in),
    .syn(syn), .ac0(ac0), .xor_pol(xor_pol), .ac1(ac1), .pre_en(pre_en), .pre_val(pre_val),
    .pin_out(e_out), .pin_oe(e_oe), .fb(e_fb), .cfg_bad(e_bad));

  // {syn, ac0, ac1, xor, pterm[7:0], pin_in, nbr_in, exp_out, exp_oe, exp_fb}
  localparam logic [16:0] VEC [10] = '{
    17'b1_1_1_1_00000010_1_0_1_0_1,   // R5 R7
    17'b1_1_1_0_00000001_0_1_1_1_0,   // R5 enable term not in sum
    17'b1_1_1_1_10000001_1_0_1_1_1,   // R5
    17'b1_1_1_0_01000001_0_1_0_1_0,   // R5 R3
    17'b0_1_1_1_00000011_0_1_1_1_0,   // R5 R6
    17'b0_1_1_0_00000000_1_0_1_0_1,   // R5 R6
    17'b1_0_0_1_00000001_0_1_1_1_1,   // R8 R10 eight terms
    17'b1_0_0_0_00000001_1_0_0_1_0,   // R8 R3
    17'b1_0_1_1_00000000_1_1_0_0_1,   // R9 R10
    17'b0_0_0_1_10000000_0_0_1_1_0    // R1 treated as simple
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    por_n = 1'b0; oe_n = 1'b0; pin_in = 1'b0; nbr_in = 1'b0;
    syn = 1'b0; ac0 = 1'b1; ac1 = 1'b0; xor_pol = 1'b0;
    pre_en = 1'b0; pre_val = 1'b0; pterm = 8'hFF;
    repeat (2) @(negedge clk);
    // R11: reset state, registered pin high for either polarity
    check("R11 pin_out xor0", m_out, 1'b1);
    check("R11 fb", m_fb, 1'b0);
    check("R2 pin_oe", m_oe, 1'b1);
    xor_pol = 1'b1; #1;
    check("R11 pin_out xor1", m_out, 1'b1);
    check("R1 cfg_bad reg", m_bad, 1'b0);
    por_n = 1'b1;

    // table walk, combinational configurations
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      {syn, ac0, ac1, xor_pol, pterm, pin_in, nbr_in} = VEC[i][16:3];
      #1;
      check($sformatf("R5/R8 vec%0d pin_out", i), m_out, VEC[i][2]);
      check($sformatf("R5/R9 vec%0d pin_oe", i), m_oe, VEC[i][1]);
      check($sformatf("R6/R7/R10 vec%0d fb", i), m_fb, VEC[i][0]);
    end
    check("R1 cfg_bad illegal", m_bad, 1'b1);
    syn = 1'b1; ac0 = 1'b0; #1;
    check("R1 cfg_bad simple", m_bad, 1'b0);

    // R10 centre cell: simple, ac1=1 still drives, no feedback
    syn = 1'b1; ac0 = 1'b0; ac1 = 1'b1; xor_pol = 1'b1; pterm = 8'h04; nbr_in = 1'b1; #1;
    check("R10 centre pin_oe", c_oe, 1'b1);
    check("R10 centre pin_out", c_out, 1'b1);
    check("R10 centre fb", c_fb, 1'b0);
    check("R10 end fb", e_fb, 1'b1);
    // R7 end cell in complex mode
    ac0 = 1'b1; pin_in = 1'b1; #1;
    check("R7 end fb", e_fb, 1'b0);
    check("R7 centre fb", c_fb, 1'b1);

    // registered cell through the register
    @(negedge clk);
    syn = 1'b0; ac0 = 1'b1; ac1 = 1'b0; oe_n = 1'b0;
    xor_pol = 1'b1; pterm = 8'h01; tick();
    check("R3 active high sum1", m_out, 1'b1);
    check("R4 fb state", m_fb, 1'b0);
    xor_pol = 1'b0; tick();
    check("R3 active low sum1", m_out, 1'b0);
    check("R4 fb state", m_fb, 1'b1);
    xor_pol = 1'b1; pterm = 8'h00; tick();
    check("R3 active high sum0", m_out, 1'b0);
    xor_pol = 1'b0; tick();
    check("R3 active low sum0", m_out, 1'b1);
    check("R4 fb state", m_fb, 1'b0);
    oe_n = 1'b1; #1;
    check("R2 pin_oe off", m_oe, 1'b0);
    oe_n = 1'b0;

    // R12 preload overrides a contrary array value
    pre_en = 1'b1; pre_val = 1'b1; tick();
    check("R12 preload fb", m_fb, 1'b1);
    check("R12 preload pin", m_out, 1'b0);
    pre_val = 1'b0; pterm = 8'hFF; tick();
    check("R12 preload zero", m_fb, 1'b0);
    pre_en = 1'b0;

    // R13 hold while combinational
    ac1 = 1'b1; pterm = 8'hFF; xor_pol = 1'b0; tick(); tick();
    ac1 = 1'b0; #1;
    check("R13 state held", m_fb, 1'b0);
    tick();
    check("R4 reloads", m_fb, 1'b1);

    // R11 asynchronous clear mid-run
    #3 por_n = 1'b0; #1;
    check("R11 async clear fb", m_fb, 1'b0);
    check("R11 async clear pin", m_out, 1'b1);
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule